// File: doc/BRIEF.md
# Burst Beat Address Sequencer

This block turns one accepted read or write address request into the byte address of every data beat in that burst. The request carries a start address, a two-bit burst kind, a length field and a size field. Once it is captured, the block presents the first beat's address and moves to the next beat on each advance pulse. At the same time it reports the beat index and flags the final beat of the burst.

Three burst kinds are supported: a fixed address, an incrementing address, and an address that wraps inside a window. The block checks each request when it captures it. It raises an error flag for an encoding it cannot honour, and in that case it still walks the full beat count so that the data channel can drain. It also raises a separate flag when an incrementing burst leaves its address page. It enforces nothing beyond raising these flags. When the last beat is consumed the block becomes idle, raises its done flag and accepts the next request.

Top module: `burst_addr_gen`

## Requirements
- R1: A request is captured only in a cycle where `req_valid` and `req_ready` are both high. `req_ready` is high exactly when no burst is in progress, so a request presented during a burst is ignored.
- R2: A burst has `req_len`+1 beats. `beat_idx` starts at 0 and rises by one per accepted advance. `beat_last` is high exactly while `beat_idx` equals `req_len`.
- R3: An advance on the last beat ends the burst. `busy` falls and `done` rises, and `done` stays high until the next capture. While idle, `advance` changes nothing.
- R4: Kind 2'b00 (fixed): every beat carries the start address.
- R5: Kind 2'b01 (incrementing): beat 0 carries the start address. Beat k carries the start address rounded down to a multiple of 2^`req_size` bytes, plus k·2^`req_size`, taken modulo 2^ADDR_W.
- R6: Kind 2'b10 (wrapping): the window is (beats·2^`req_size`) bytes and its base is the start address rounded down to that window size. Each beat adds 2^`req_size`, and reaching the window's top returns the address to the base.
- R7: `err` is high for the whole burst in three cases: kind 2'b11, a wrapping burst whose beat count is not 2, 4, 8 or 16, or a wrapping start address that is not a multiple of 2^`req_size`. Every beat of such a burst carries the start address, and the full beat count is still produced.
- R8: `page_err` is high for an incrementing burst when the bytes from the rounded-down start address through the end of its last beat span more than one 2^PAGE_LG-byte page. This includes a span that runs past the top of the address space. Beat addresses are unaffected.
- R9: Reset is synchronous and active high. It clears `busy`, `done`, `beat_addr`, `beat_idx`, `beat_last`, `err` and `page_err`, and leaves `req_ready` high, even when it arrives mid-burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can capture a request |
| req_addr | input | ADDR_W | Start byte address |
| req_kind | input | 2 | Burst kind: 00 fixed, 01 incrementing, 10 wrapping, 11 reserved |
| req_len | input | LEN_W | Beat count minus one |
| req_size | input | SIZE_W | log2 of bytes per beat |
| advance | input | 1 | Consume the current beat |
| busy | output | 1 | Burst in progress |
| done | output | 1 | Last burst finished, held until next capture |
| beat_addr | output | ADDR_W | Byte address of the current beat |
| beat_idx | output | LEN_W | Index of the current beat |
| beat_last | output | 1 | Current beat is the final one |
| err | output | 1 | Captured request was illegal |
| page_err | output | 1 | Incrementing burst leaves its page |

## Verification
The bench builds the block with a 16-bit address and 256-byte pages, keeping the 8-bit length and 3-bit size fields. Short incrementing bursts can then cross a page and roll past the top of the address space, and every size and the full 256-beat length stay reachable. A behavioural model builds each burst's expected address list with plain integer division and modulo, and the bench compares every output against it once per clock. The stimulus includes stalled advances and requests offered mid-burst.

// File: rtl/burst_pkg.sv
`timescale 1ns/1ps
package burst_pkg;

  typedef enum logic [1:0] {
    BK_FIXED = 2'b00,
    BK_INCR  = 2'b01,
    BK_WRAP  = 2'b10,
    BK_RSVD  = 2'b11
  } burst_kind_e;

  // True when a wrapping burst may use this beat count.
  function automatic logic wrap_count_ok(input int unsigned beats);
    return (beats == 2) || (beats == 4) || (beats == 8) || (beats == 16);
  endfunction

  // log2 of a legal wrapping beat count; zero otherwise.
  function automatic logic [2:0] wrap_count_lg(input int unsigned beats);
    case (beats)
      2:       return 3'd1;
      4:       return 3'd2;
      8:       return 3'd3;
      16:      return 3'd4;
      default: return 3'd0;
    endcase
  endfunction

  // Mask of byte-offset bits for a 2**sh_amt aligned quantity.
  function automatic logic [63:0] low_mask(input int unsigned sh_amt);
    return (64'd1 << sh_amt) - 64'd1;
  endfunction

endpackage

// File: rtl/burst_req_check.sv
`timescale 1ns/1ps
module burst_req_check
  import burst_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int LEN_W   = 8,
  parameter int SIZE_W  = 3,
  parameter int PAGE_LG = 12
) (
  input  logic [ADDR_W-1:0] start_i,
  input  logic [1:0]        kind_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [SIZE_W-1:0] size_i,
  output logic              err_o,
  output logic              page_err_o,
  output logic [ADDR_W-1:0] size_mask_o,
  output logic [ADDR_W-1:0] wrap_mask_o
);
  localparam int MAX_SH = (1 << SIZE_W) - 1;
  localparam int EXT_W  = ADDR_W + LEN_W + MAX_SH + 2;
  localparam int SH_W   = SIZE_W + 3;

  burst_kind_e        kind;
  logic [LEN_W:0]     beats;
  logic [2:0]         wrap_lg;
  logic [SH_W-1:0]    wrap_sh;
  logic               wrap_len_ok;
  logic               misaligned;
  logic [EXT_W-1:0]   start_ext;
  logic [EXT_W-1:0]   span_ext;
  logic [EXT_W-1:0]   end_ext;

  assign kind        = burst_kind_e'(kind_i);
  assign beats       = {1'b0, len_i} + {{LEN_W{1'b0}}, 1'b1};
  assign wrap_len_ok = wrap_count_ok(32'(beats));
  assign wrap_lg     = wrap_count_lg(32'(beats));
  assign wrap_sh     = SH_W'(size_i) + SH_W'(wrap_lg);

  assign size_mask_o = ADDR_W'(low_mask(32'(size_i)));
  assign wrap_mask_o = ADDR_W'(low_mask(32'(wrap_sh)));
  assign misaligned  = |(start_i & size_mask_o);

  always_comb begin
    err_o = 1'b0;
    if (kind == BK_RSVD) begin
      err_o = 1'b1;
    end else if (kind == BK_WRAP) begin
      err_o = !wrap_len_ok || misaligned;
    end
  end

  // Last byte touched by an incrementing burst, in a width that cannot overflow.
  assign start_ext = EXT_W'(start_i & ~size_mask_o);
  assign span_ext  = EXT_W'(beats) << size_i;
  assign end_ext   = start_ext + span_ext - EXT_W'(1);

  assign page_err_o = (kind == BK_INCR) &&
                      (end_ext[EXT_W-1:PAGE_LG] != start_ext[EXT_W-1:PAGE_LG]);

endmodule

// File: rtl/burst_step.sv
`timescale 1ns/1ps
module burst_step
  import burst_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] cur_i,
  input  burst_kind_e       kind_i,
  input  logic              err_i,
  input  logic [ADDR_W-1:0] size_mask_i,
  input  logic [ADDR_W-1:0] wrap_lo_i,
  input  logic [ADDR_W-1:0] wrap_mask_i,
  output logic [ADDR_W-1:0] nxt_o
);
  logic [ADDR_W-1:0] bytes;
  logic [ADDR_W-1:0] incr_nxt;
  logic [ADDR_W-1:0] wrap_nxt;

  assign bytes    = size_mask_i + ADDR_W'(1);
  assign incr_nxt = (cur_i & ~size_mask_i) + bytes;
  assign wrap_nxt = wrap_lo_i | ((cur_i + bytes) & wrap_mask_i);

  always_comb begin
    nxt_o = cur_i;
    if (!err_i) begin
      case (kind_i)
        BK_INCR: nxt_o = incr_nxt;
        BK_WRAP: nxt_o = wrap_nxt;
        default: nxt_o = cur_i;
      endcase
    end
  end

endmodule

// File: rtl/burst_beat_ctr.sv
`timescale 1ns/1ps
module burst_beat_ctr #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             step_i,
  output logic [LEN_W-1:0] idx_o,
  output logic [LEN_W-1:0] len_o,
  output logic             last_o,
  output logic             final_o
);
  logic [LEN_W-1:0] idx_nxt;

  assign idx_nxt = idx_o + LEN_W'(1);
  assign final_o = step_i && last_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_o  <= '0;
      len_o  <= '0;
      last_o <= 1'b0;
    end else if (load_i) begin
      idx_o  <= '0;
      len_o  <= len_i;
      last_o <= (len_i == '0);
    end else if (step_i) begin
      if (last_o) begin
        last_o <= 1'b0;
      end else begin
        idx_o  <= idx_nxt;
        last_o <= (idx_nxt == len_o);
      end
    end
  end

endmodule

// File: rtl/burst_addr_gen.sv
`timescale 1ns/1ps
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int LEN_W   = 8,
  parameter int SIZE_W  = 3,
  parameter int PAGE_LG = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_kind,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [SIZE_W-1:0] req_size,
  input  logic              advance,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] beat_addr,
  output logic [LEN_W-1:0]  beat_idx,
  output logic              beat_last,
  output logic              err,
  output logic              page_err
);
  // Named internal events, also observed by the bound checker.
  logic              ld_fire;
  logic              step_fire;
  logic              burst_end;
  burst_kind_e       kind_q;
  logic [LEN_W-1:0]  len_q;
  logic [ADDR_W-1:0] size_mask_q;
  logic [ADDR_W-1:0] wrap_lo_q;
  logic [ADDR_W-1:0] wrap_mask_q;
  logic [ADDR_W-1:0] addr_nxt;

  logic              chk_err;
  logic              chk_page_err;
  logic [ADDR_W-1:0] chk_size_mask;
  logic [ADDR_W-1:0] chk_wrap_mask;

  logic              busy_q;
  logic              done_q;
  logic              err_q;
  logic              page_err_q;
  logic [ADDR_W-1:0] addr_q;

  assign req_ready = !busy_q;
  assign ld_fire   = req_valid && req_ready;
  assign step_fire = advance && busy_q;

  burst_req_check #(
    .ADDR_W (ADDR_W),
    .LEN_W  (LEN_W),
    .SIZE_W (SIZE_W),
    .PAGE_LG(PAGE_LG)
  ) req_check_i (
    .start_i    (req_addr),
    .kind_i     (req_kind),
    .len_i      (req_len),
    .size_i     (req_size),
    .err_o      (chk_err),
    .page_err_o (chk_page_err),
    .size_mask_o(chk_size_mask),
    .wrap_mask_o(chk_wrap_mask)
  );

  burst_step #(
    .ADDR_W(ADDR_W)
  ) step_i (
    .cur_i      (addr_q),
    .kind_i     (kind_q),
    .err_i      (err_q),
    .size_mask_i(size_mask_q),
    .wrap_lo_i  (wrap_lo_q),
    .wrap_mask_i(wrap_mask_q),
    .nxt_o      (addr_nxt)
  );

  burst_beat_ctr #(
    .LEN_W(LEN_W)
  ) beat_ctr_i (
    .clk    (clk),
    .rst    (rst),
    .load_i (ld_fire),
    .len_i  (req_len),
    .step_i (step_fire),
    .idx_o  (beat_idx),
    .len_o  (len_q),
    .last_o (beat_last),
    .final_o(burst_end)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q      <= 1'b0;
      done_q      <= 1'b0;
      err_q       <= 1'b0;
      page_err_q  <= 1'b0;
      addr_q      <= '0;
      kind_q      <= BK_FIXED;
      size_mask_q <= '0;
      wrap_lo_q   <= '0;
      wrap_mask_q <= '0;
    end else if (ld_fire) begin
      busy_q      <= 1'b1;
      done_q      <= 1'b0;
      err_q       <= chk_err;
      page_err_q  <= chk_page_err;
      addr_q      <= req_addr;
      kind_q      <= burst_kind_e'(req_kind);
      size_mask_q <= chk_size_mask;
      wrap_lo_q   <= req_addr & ~chk_wrap_mask;
      wrap_mask_q <= chk_wrap_mask;
    end else if (burst_end) begin
      busy_q <= 1'b0;
      done_q <= 1'b1;
    end else if (step_fire) begin
      addr_q <= addr_nxt;
    end
  end

  assign busy      = busy_q;
  assign done      = done_q;
  assign err       = err_q;
  assign page_err  = page_err_q;
  assign beat_addr = addr_q;

endmodule

// File: rtl/burst_addr_gen_chk.sv
`timescale 1ns/1ps
module burst_addr_gen_chk #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              done,
  input logic [ADDR_W-1:0] beat_addr,
  input logic [LEN_W-1:0]  beat_idx,
  input logic              beat_last,
  input logic              err,
  input logic              ld_fire,
  input logic              step_fire,
  input logic [1:0]        kind_q,
  input logic [LEN_W-1:0]  len_q,
  input logic [ADDR_W-1:0] wrap_lo_q,
  input logic [ADDR_W-1:0] wrap_mask_q
);

  assert_capture_R1: assert property (@(posedge clk) disable iff (rst)
    ld_fire |=> busy && !done && (beat_idx == '0));

  assert_last_pos_R2: assert property (@(posedge clk) disable iff (rst)
    busy && beat_last |-> beat_idx == len_q);

  assert_idx_step_R2: assert property (@(posedge clk) disable iff (rst)
    step_fire && !beat_last |=> beat_idx == LEN_W'($past(beat_idx) + LEN_W'(1)));

  assert_finish_R3: assert property (@(posedge clk) disable iff (rst)
    step_fire && beat_last |=> !busy && done);

  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !busy && !ld_fire |=> $stable(beat_addr) && $stable(beat_idx));

  assert_fixed_addr_R4: assert property (@(posedge clk) disable iff (rst)
    step_fire && (kind_q == 2'b00) |=> $stable(beat_addr));

  assert_wrap_window_R6: assert property (@(posedge clk) disable iff (rst)
    busy && (kind_q == 2'b10) && !err |-> (beat_addr & ~wrap_mask_q) == wrap_lo_q);

  assert_err_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !ld_fire |=> $stable(err));

  assert_err_addr_R7: assert property (@(posedge clk) disable iff (rst)
    step_fire && err |=> $stable(beat_addr));

endmodule

bind burst_addr_gen burst_addr_gen_chk #(
  .ADDR_W(ADDR_W),
  .LEN_W (LEN_W)
) chk_i (
  .clk        (clk),
  .rst        (rst),
  .busy       (busy),
  .done       (done),
  .beat_addr  (beat_addr),
  .beat_idx   (beat_idx),
  .beat_last  (beat_last),
  .err        (err),
  .ld_fire    (ld_fire),
  .step_fire  (step_fire),
  .kind_q     (kind_q),
  .len_q      (len_q),
  .wrap_lo_q  (wrap_lo_q),
  .wrap_mask_q(wrap_mask_q)
);

// File: tb/burst_addr_gen_tb.sv
`timescale 1ns/1ps
module burst_addr_gen_tb_top;
  localparam int AW = 16;
  localparam int LW = 8;
  localparam int SW = 3;
  localparam int PG = 8;
  localparam int ASPACE = 1 << AW;
  localparam int PAGE = 1 << PG;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [1:0]    req_kind = '0;
  logic [LW-1:0] req_len = '0;
  logic [SW-1:0] req_size = '0;
  logic          advance = 1'b0;
  logic          busy, done, beat_last, err, page_err;
  logic [AW-1:0] beat_addr;
  logic [LW-1:0] beat_idx;

  int total = 0;
  int bad = 0;

  // Reference model state
  int exp_a[$];
  int m_addr, m_idx, m_len, m_kind;
  bit m_busy, m_done, m_last, m_err, m_perr;

  always #2.5 clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW), .LEN_W(LW), .SIZE_W(SW), .PAGE_LG(PG)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_kind(req_kind), .req_len(req_len), .req_size(req_size),
    .advance(advance), .busy(busy), .done(done), .beat_addr(beat_addr),
    .beat_idx(beat_idx), .beat_last(beat_last), .err(err), .page_err(page_err)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, expv, $time);
    end
  endtask

  function automatic string addr_tag();
    if (m_err) return "R7 addr";
    case (m_kind)
      0: return "R4 addr";
      1: return "R5 addr";
      default: return "R6 addr";
    endcase
  endfunction

  task automatic compare_all(input bit in_reset);
    string t;
    t = in_reset ? "R9" : "";
    chk(req_ready == !m_busy, in_reset ? "R9 ready" : "R1 ready", int'(req_ready), int'(!m_busy));
    chk(busy == m_busy, in_reset ? "R9 busy" : "R3 busy", int'(busy), int'(m_busy));
    chk(done == m_done, in_reset ? "R9 done" : "R3 done", int'(done), int'(m_done));
    chk(int'(beat_idx) == m_idx, in_reset ? "R9 idx" : "R2 idx", int'(beat_idx), m_idx);
    chk(beat_last == m_last, in_reset ? "R9 last" : "R2 last", int'(beat_last), int'(m_last));
    chk(int'(beat_addr) == m_addr, in_reset ? "R9 addr" : addr_tag(), int'(beat_addr), m_addr);
    chk(err == m_err, in_reset ? "R9 err" : "R7 err", int'(err), int'(m_err));
    chk(page_err == m_perr, in_reset ? "R9 page" : "R8 page", int'(page_err), int'(m_perr));
    if (t.len() > 0) total = total;
  endtask

  task automatic model_reset();
    exp_a.delete();
    m_addr = 0; m_idx = 0; m_len = 0; m_kind = 0;
    m_busy = 0; m_done = 0; m_last = 0; m_err = 0; m_perr = 0;
  endtask

  task automatic model_load(input int a, input int k, input int l, input int s);
    int beats, bytes, tot, lo, al;
    bit bad_req;
    beats = l + 1;
    bytes = 1 << s;
    al = (a / bytes) * bytes;
    bad_req = (k == 3) ||
              (k == 2 && !(beats == 2 || beats == 4 || beats == 8 || beats == 16)) ||
              (k == 2 && (a % bytes) != 0);
    exp_a.delete();
    for (int i = 0; i < beats; i++) begin
      if (bad_req || k == 0) exp_a.push_back(a);
      else if (k == 1) exp_a.push_back(i == 0 ? a : (al + i * bytes) % ASPACE);
      else begin
        tot = beats * bytes;
        lo = (a / tot) * tot;
        exp_a.push_back(lo + ((a - lo) + i * bytes) % tot);
      end
    end
    m_err  = bad_req;
    m_perr = (k == 1) && ((al / PAGE) != ((al + beats * bytes - 1) / PAGE));
    m_busy = 1; m_done = 0; m_idx = 0; m_len = l; m_kind = k;
    m_last = (l == 0);
    m_addr = exp_a[0];
  endtask

  // Drive at the falling edge, update the model for the coming rising edge,
  // then compare at the next falling edge.
  task automatic step_cycle(input bit v, input bit adv);
    req_valid = v;
    advance   = adv;
    if (v && !m_busy) begin
      model_load(int'(req_addr), int'(req_kind), int'(req_len), int'(req_size));
    end else if (adv && m_busy) begin
      if (m_last) begin
        m_busy = 0; m_done = 1; m_last = 0;
      end else begin
        m_idx++;
        m_last = (m_idx == m_len);
        m_addr = exp_a[m_idx];
      end
    end
    @(posedge clk);
    @(negedge clk);
    compare_all(1'b0);
  endtask

  // stall: drop advance on every third beat; poke: offer another request mid-burst (R1)
  task automatic run_burst(input int a, input int k, input int l, input int s,
                           input bit stall, input bit poke);
    int n;
    req_addr = AW'(a); req_kind = 2'(k); req_len = LW'(l); req_size = SW'(s);
    step_cycle(1'b1, 1'b0);
    req_addr = AW'(a ^ 16'h0F0F); req_kind = 2'(3 - k); req_len = LW'(l ^ 1); req_size = SW'(7 - s);
    n = 0;
    while (m_busy) begin
      n++;
      step_cycle(poke && !m_last, !(stall && (n % 3 == 0)));
    end
    // R3: advance while idle leaves every output alone
    step_cycle(1'b0, 1'b1);
  endtask

  task automatic do_reset(input int n);
    rst = 1'b1; req_valid = 1'b0; advance = 1'b0;
    repeat (n) @(posedge clk);
    @(negedge clk);
    model_reset();
    compare_all(1'b1);
    rst = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    model_reset();
    @(negedge clk);
    do_reset(3);                                  // R9 reset state
    run_burst(16'h1234, 0, 3, 2, 1'b0, 1'b0);     // R4 fixed
    run_burst(16'h1003, 1, 4, 2, 1'b1, 1'b0);     // R5 unaligned start, stalls
    run_burst(16'h2000, 1, 0, 3, 1'b0, 1'b0);     // R2 single beat
    run_burst(16'h0138, 2, 3, 2, 1'b0, 1'b1);     // R6 wrap, R1 poke ignored
    run_burst(16'h0280, 2, 15, 7, 1'b1, 1'b0);    // R6 largest window
    run_burst(16'h4444, 2, 1, 0, 1'b0, 1'b0);     // R6 two-beat byte wrap
    run_burst(16'h0500, 3, 2, 1, 1'b0, 1'b0);     // R7 reserved kind
    run_burst(16'h0600, 2, 2, 2, 1'b0, 1'b0);     // R7 three-beat wrap
    run_burst(16'h0702, 2, 3, 2, 1'b1, 1'b0);     // R7 misaligned wrap start
    run_burst(16'h00F0, 1, 3, 3, 1'b0, 1'b0);     // R8 page crossing
    run_burst(16'hFFF8, 1, 3, 2, 1'b0, 1'b1);     // R5/R8 address-space rollover
    run_burst(16'h0300, 1, 255, 0, 1'b1, 1'b0);   // R2 longest burst
    // R9 reset arriving mid-burst
    req_addr = 16'h0800; req_kind = 2'b01; req_len = 8'd7; req_size = 3'd1;
    step_cycle(1'b1, 1'b0);
    step_cycle(1'b0, 1'b1);
    step_cycle(1'b0, 1'b1);
    do_reset(1);
    run_burst(16'h0900, 1, 2, 1, 1'b0, 1'b0);     // R1 capture after reset
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule